// File: doc/BRIEF.md
# Packet-Filter VM Integer ALU

This block is the integer execution unit of a 64-bit packet-filter virtual machine. Each cycle it can accept one arithmetic instruction. The instruction arrives as an 8-bit opcode, the current destination register value, the source register value and a 32-bit immediate. One clock later the block returns the 64-bit value to be written back to the destination register, together with a flag that marks an opcode the unit does not execute.

The opcode is split into three fields:
- bits [2:0] are the class, which sets the operand width;
- bit 3 chooses the second operand;
- bits [7:4] name the operation.

The same operation runs on 32-bit or 64-bit operands depending on the class. A byte-order conversion is folded into the operation space. Instruction fetch, the register file, memory access and branches belong to other blocks. The surrounding pipeline presents operands with `inValid` and takes the registered result when `outValid` is high.

Top module: `vm_int_alu`

## Requirements
- R1: While reset is held and on every cycle after a cycle with `inValid` low, `outValid`, `illegal` and `result` are all 0.
- R2: An instruction presented with `inValid` high at a clock edge produces `outValid` = 1 and its `result`/`illegal` after that same edge, one cycle of latency.
- R3: Opcode class bits [2:0] = 4 selects 32-bit operation and 7 selects 64-bit operation. Any other class sets `illegal` = 1.
- R4: Opcode bit 3 = 1 takes the second operand from `srcVal`; bit 3 = 0 takes it from `imm`. In 64-bit class the immediate is sign-extended from bit 31.
- R5: In 32-bit class both operands are cut to their low 32 bits and the 32-bit result is zero-extended, so `result[63:32]` = 0.
- R6: Operation nibble bits [7:4] encodes the following; B is the second operand:

  | Nibble | Result |
  |--------|--------|
  | 0x0 | dst + B |
  | 0x1 | dst − B |
  | 0x2 | dst × B, low bits |
  | 0x4 | OR |
  | 0x5 | AND |
  | 0xa | XOR |
  | 0xb | B |

- R7: Nibble 0x6 shifts left, 0x7 shifts right logically and 0xc shifts right arithmetically. The shift amount is B masked to 5 bits in 32-bit class and to 6 bits in 64-bit class.
- R8: Nibble 0x3 is unsigned divide and 0x9 is unsigned remainder.
  - A zero divisor makes divide return 0.
  - A zero divisor makes remainder return dst unchanged; in 32-bit class that is the zero-extended low half of dst.
- R9: Nibble 0x8 returns the two's complement negation of dst at the class width. The second operand is ignored.
- R10: Nibble 0xd in 32-bit class is byte-order conversion of dst.
  - `imm` = 16, 32 or 64 gives the width.
  - Bit 3 = 0 (little-endian) keeps the low bytes of that width and zero-extends them.
  - Bit 3 = 1 (big-endian) reverses the byte order within the width and zero-extends.
- R11: Each of the following sets `illegal` = 1 and makes `result` equal `dstVal` unchanged:
  - nibble 0xe or 0xf;
  - byte conversion with any other `imm`;
  - byte conversion in 64-bit class;
  - a bad class.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Instruction present this cycle |
| opcode | input | 8 | Instruction opcode (class, operand select, operation) |
| dstVal | input | 64 | Current destination register value |
| srcVal | input | 64 | Source register value |
| imm | input | 32 | Instruction immediate |
| outValid | output | 1 | Result valid |
| result | output | 64 | Value for the destination register |
| illegal | output | 1 | Opcode not executed by this unit |

## Verification
The bench sweeps all 256 opcodes against eight operand sets and computes each expected value arithmetically. The operand sets aim at these corner cases:
- **Width mix-ups.** A zero divisor hidden in the high half of a 64-bit source catches a 32-bit divide or remainder that sees the full register. Such a design would divide by a non-zero value instead of applying the zero rule.
- **Shift masking.** Shift operands above 31 and above 63 expose an unmasked shift, which would return 0 instead of a wrapped shift.
- **Immediate extension.** A negative immediate exposes a missing sign extension in 64-bit class, which would leave the upper word at zero.
- **Byte conversion.** A non-power width immediate and the 64-bit class variant must raise the flag and pass dst through. A swap applied to the wrong width would reverse the wrong bytes.

// File: rtl/vm_alu_pkg.sv
package vm_alu_pkg;

  parameter int DATA_W = 64;
  parameter int HALF_W = 32;
  parameter int IMM_W  = 32;

  localparam logic [2:0] CLASS_NARROW = 3'd4;
  localparam logic [2:0] CLASS_WIDE   = 3'd7;

  typedef enum logic [3:0] {
    OP_ADD  = 4'h0,
    OP_SUB  = 4'h1,
    OP_MUL  = 4'h2,
    OP_DIV  = 4'h3,
    OP_OR   = 4'h4,
    OP_AND  = 4'h5,
    OP_SHL  = 4'h6,
    OP_SHR  = 4'h7,
    OP_NEG  = 4'h8,
    OP_MOD  = 4'h9,
    OP_XOR  = 4'ha,
    OP_MOV  = 4'hb,
    OP_ASHR = 4'hc,
    OP_SWAP = 4'hd,
    OP_RSVE = 4'he,
    OP_RSVF = 4'hf
  } aluOp_e;

  typedef enum logic [1:0] {
    SW_16 = 2'd0,
    SW_32 = 2'd1,
    SW_64 = 2'd2
  } swapW_e;

  // strobes from control to datapath
  typedef struct packed {
    aluOp_e op;
    logic   wide;
    logic   useReg;
    logic   bigEnd;
    swapW_e swapW;
    logic   legal;
  } aluCtrl_t;

endpackage

// File: rtl/vm_alu_ctrl.sv
module vm_alu_ctrl
  import vm_alu_pkg::*;
#(
  parameter int IW = IMM_W
) (
  input  logic [7:0]    opcode,
  input  logic [IW-1:0] imm,
  output aluCtrl_t      ctrl
);

  logic [2:0] opClass;
  logic [3:0] opNib;
  logic       classOk;
  logic       immIs16;
  logic       immIs32;
  logic       immIs64;
  logic       swapOk;

  assign opClass = opcode[2:0];
  assign opNib   = opcode[7:4];
  assign classOk = (opClass == CLASS_NARROW) || (opClass == CLASS_WIDE);
  assign immIs16 = (imm == IW'(16));
  assign immIs32 = (imm == IW'(32));
  assign immIs64 = (imm == IW'(64));
  assign swapOk  = (opClass == CLASS_NARROW) && (immIs16 || immIs32 || immIs64);

  always_comb begin
    ctrl        = '0;
    ctrl.op     = aluOp_e'(opNib);
    ctrl.wide   = (opClass == CLASS_WIDE);
    ctrl.useReg = opcode[3];
    ctrl.bigEnd = opcode[3];
    if (immIs16)      ctrl.swapW = SW_16;
    else if (immIs32) ctrl.swapW = SW_32;
    else              ctrl.swapW = SW_64;
    unique case (ctrl.op)
      OP_RSVE, OP_RSVF: ctrl.legal = 1'b0;
      OP_SWAP:          ctrl.legal = swapOk;
      default:          ctrl.legal = classOk;
    endcase
  end

endmodule

// File: rtl/vm_alu_lane.sv
module vm_alu_lane
  import vm_alu_pkg::*;
#(
  parameter int W = 64
) (
  input  aluOp_e       op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);

  localparam int SH_W = $clog2(W);

  logic [SH_W-1:0] shAmt;
  logic            bZero;
  logic [W-1:0]    quot;
  logic [W-1:0]    remd;

  assign shAmt = b[SH_W-1:0];
  assign bZero = (b == '0);
  assign quot  = bZero ? '0 : (a / b);
  assign remd  = bZero ? a  : (a % b);

  always_comb begin
    unique case (op)
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_MUL:  y = a * b;
      OP_DIV:  y = quot;
      OP_OR:   y = a | b;
      OP_AND:  y = a & b;
      OP_SHL:  y = a << shAmt;
      OP_SHR:  y = a >> shAmt;
      OP_NEG:  y = '0 - a;
      OP_MOD:  y = remd;
      OP_XOR:  y = a ^ b;
      OP_MOV:  y = b;
      OP_ASHR: y = $unsigned($signed(a) >>> shAmt);
      default: y = a;
    endcase
  end

endmodule

// File: rtl/vm_alu_swap.sv
module vm_alu_swap
  import vm_alu_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic [DW-1:0] x,
  input  logic          bigEnd,
  input  swapW_e        swapW,
  output logic [DW-1:0] y
);

  localparam int N_WIDTHS = 3;

  logic [DW-1:0] leArr [N_WIDTHS];
  logic [DW-1:0] beArr [N_WIDTHS];

  for (genvar gw = 0; gw < N_WIDTHS; gw++) begin : g_width
    localparam int NB = 2 << gw;
    logic [8*NB-1:0] rev;
    always_comb begin
      for (int i = 0; i < NB; i++) begin
        rev[8*i +: 8] = x[8*(NB-1-i) +: 8];
      end
    end
    assign leArr[gw] = DW'(x[8*NB-1:0]);
    assign beArr[gw] = DW'(rev);
  end

  always_comb begin
    unique case (swapW)
      SW_16:   y = bigEnd ? beArr[0] : leArr[0];
      SW_32:   y = bigEnd ? beArr[1] : leArr[1];
      default: y = bigEnd ? beArr[2] : leArr[2];
    endcase
  end

endmodule

// File: rtl/vm_alu_dp.sv
module vm_alu_dp
  import vm_alu_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int HW = HALF_W,
  parameter int IW = IMM_W
) (
  input  aluCtrl_t      ctrl,
  input  logic [DW-1:0] dstVal,
  input  logic [DW-1:0] srcVal,
  input  logic [IW-1:0] imm,
  output logic [DW-1:0] res
);

  localparam int N_LANES = 2;

  logic [DW-1:0] immExt;
  logic [DW-1:0] opB;
  logic [DW-1:0] laneRes [N_LANES];
  logic [DW-1:0] swapRes;

  assign immExt = {{(DW-IW){imm[IW-1]}}, imm};
  assign opB    = ctrl.useReg ? srcVal : immExt;

  // lane 0 is the narrow class, lane 1 the wide class
  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    localparam int LW = (g == 0) ? HW : DW;
    logic [LW-1:0] laneY;
    vm_alu_lane #(.W(LW)) uLane (
      .op (ctrl.op),
      .a  (dstVal[LW-1:0]),
      .b  (opB[LW-1:0]),
      .y  (laneY)
    );
    assign laneRes[g] = DW'(laneY);
  end

  vm_alu_swap #(.DW(DW)) uSwap (
    .x      (dstVal),
    .bigEnd (ctrl.bigEnd),
    .swapW  (ctrl.swapW),
    .y      (swapRes)
  );

  always_comb begin
    if (!ctrl.legal)              res = dstVal;
    else if (ctrl.op == OP_SWAP)  res = swapRes;
    else if (ctrl.wide)           res = laneRes[1];
    else                          res = laneRes[0];
  end

endmodule

// File: rtl/vm_int_alu.sv
module vm_int_alu
  import vm_alu_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int IW = IMM_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  logic [7:0]    opcode,
  input  logic [DW-1:0] dstVal,
  input  logic [DW-1:0] srcVal,
  input  logic [IW-1:0] imm,
  output logic          outValid,
  output logic [DW-1:0] result,
  output logic          illegal
);

  aluCtrl_t      ctrl;
  logic [DW-1:0] dpRes;

  vm_alu_ctrl #(.IW(IW)) uCtrl (
    .opcode (opcode),
    .imm    (imm),
    .ctrl   (ctrl)
  );

  vm_alu_dp #(.DW(DW), .HW(DW/2), .IW(IW)) uDp (
    .ctrl   (ctrl),
    .dstVal (dstVal),
    .srcVal (srcVal),
    .imm    (imm),
    .res    (dpRes)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      result   <= '0;
      illegal  <= 1'b0;
    end else begin
      outValid <= inValid;
      result   <= inValid ? dpRes : '0;
      illegal  <= inValid & ~ctrl.legal;
    end
  end

endmodule

// File: rtl/vm_alu_chk.sv
module vm_alu_chk #(
  parameter int DW = 64,
  parameter int IW = 32
) (
  input logic          clk,
  input logic          rstN,
  input logic          inValid,
  input logic [7:0]    opcode,
  input logic [DW-1:0] dstVal,
  input logic [DW-1:0] srcVal,
  input logic [IW-1:0] imm,
  input logic          outValid,
  input logic [DW-1:0] result,
  input logic          illegal
);

  // R1
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!outValid && !illegal && result == '0));

  // R2
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  // R3, R11
  a_r3_bad_class: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opcode[2:0] != 3'd4 && opcode[2:0] != 3'd7)
      |=> (illegal && result == $past(dstVal)));

  // R5
  a_r5_zero_ext: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opcode[2:0] == 3'd4 && opcode[7:4] != 4'hd
      && opcode[7:4] < 4'he) |=> (result[DW-1:32] == '0 && !illegal));

  // R8
  a_r8_div_zero: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opcode == 8'h3f && srcVal == '0) |=> (result == '0));

  // R10
  a_r10_le16: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opcode == 8'hd4 && imm == IW'(16))
      |=> (result == DW'($past(dstVal[15:0]))));

endmodule

bind vm_int_alu vm_alu_chk #(.DW(DW), .IW(IW)) uChk (.*);

// File: tb/vm_int_alu_test.sv
module vm_int_alu_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [7:0]  opcode = '0;
  logic [63:0] dstVal = '0;
  logic [63:0] srcVal = '0;
  logic [31:0] imm = '0;
  logic        outValid;
  logic [63:0] result;
  logic        illegal;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  vm_int_alu uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opcode(opcode),
    .dstVal(dstVal), .srcVal(srcVal), .imm(imm),
    .outValid(outValid), .result(result), .illegal(illegal)
  );

  logic [63:0] dS [8];
  logic [63:0] sS [8];
  logic [31:0] iS [8];

  function automatic void model(input logic [7:0] op, input logic [63:0] d,
                                input logic [63:0] s, input logic [31:0] im,
                                output logic [63:0] r, output logic il);
    logic [2:0]  c;
    logic [3:0]  n;
    logic [63:0] b;
    logic [31:0] a32;
    logic [31:0] b32;
    logic [31:0] r32;
    int          nb;
    c = op[2:0];
    n = op[7:4];
    b = op[3] ? s : {{32{im[31]}}, im};
    a32 = d[31:0];
    b32 = b[31:0];
    r = d;
    il = 1'b1;
    if (c != 3'd4 && c != 3'd7) return;
    if (n >= 4'he) return;
    if (n == 4'hd) begin
      if (c != 3'd4) return;
      if (im == 32'd16) nb = 2;
      else if (im == 32'd32) nb = 4;
      else if (im == 32'd64) nb = 8;
      else return;
      il = 1'b0;
      r = '0;
      for (int i = 0; i < nb; i++) begin
        if (op[3]) r[8*i +: 8] = d[8*(nb-1-i) +: 8];
        else       r[8*i +: 8] = d[8*i +: 8];
      end
      return;
    end
    il = 1'b0;
    if (c == 3'd7) begin
      case (n)
        4'h0: r = d + b;
        4'h1: r = d - b;
        4'h2: r = d * b;
        4'h3: r = (b == 0) ? 64'd0 : d / b;
        4'h4: r = d | b;
        4'h5: r = d & b;
        4'h6: r = d << b[5:0];
        4'h7: r = d >> b[5:0];
        4'h8: r = 64'd0 - d;
        4'h9: r = (b == 0) ? d : d % b;
        4'ha: r = d ^ b;
        4'hb: r = b;
        default: r = $unsigned($signed(d) >>> b[5:0]);
      endcase
    end else begin
      case (n)
        4'h0: r32 = a32 + b32;
        4'h1: r32 = a32 - b32;
        4'h2: r32 = a32 * b32;
        4'h3: r32 = (b32 == 0) ? 32'd0 : a32 / b32;
        4'h4: r32 = a32 | b32;
        4'h5: r32 = a32 & b32;
        4'h6: r32 = a32 << b32[4:0];
        4'h7: r32 = a32 >> b32[4:0];
        4'h8: r32 = 32'd0 - a32;
        4'h9: r32 = (b32 == 0) ? a32 : a32 % b32;
        4'ha: r32 = a32 ^ b32;
        4'hb: r32 = b32;
        default: r32 = $unsigned($signed(a32) >>> b32[4:0]);
      endcase
      r = {32'd0, r32};
    end
  endfunction

  function automatic string tagOf(input logic [7:0] op);
    if (op[2:0] != 3'd4 && op[2:0] != 3'd7) return "R3";
    case (op[7:4])
      4'he, 4'hf:       return "R11";
      4'hd:             return "R10";
      4'h6, 4'h7, 4'hc: return "R7";
      4'h3, 4'h9:       return "R8";
      4'h8:             return "R9";
      default:          return "R6";
    endcase
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp,
                       input logic actIl, input logic expIl, input logic [7:0] op);
    checks++;
    if (act !== exp || actIl !== expIl) begin
      errors++;
      $display("FAIL %s op=%02h result=%h expected=%h illegal=%b expected=%b",
               tag, op, act, exp, actIl, expIl);
    end
  endtask

  task automatic runOne(input logic [7:0] op, input logic [63:0] d, input logic [63:0] s,
                        input logic [31:0] im, input string tag);
    logic [63:0] er;
    logic        ei;
    @(negedge clk);
    opcode = op; dstVal = d; srcVal = s; imm = im; inValid = 1'b1;
    @(negedge clk);
    model(op, d, s, im, er, ei);
    check(tag, result, er, illegal, ei, op);
    checks++;
    if (outValid !== 1'b1) begin
      errors++;
      $display("FAIL R2 outValid=%b expected=1", outValid);
    end
    inValid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R2 watchdog expired result=%h expected=completion", result);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    dS[0] = 64'h0123_4567_89ab_cdef; sS[0] = 64'h3;                   iS[0] = 32'd16;
    dS[1] = 64'hfedc_ba98_7654_3210; sS[1] = 64'h0;                   iS[1] = 32'd32;
    dS[2] = 64'h8000_0000_8000_0001; sS[2] = 64'hffff_ffff_ffff_ffe5; iS[2] = 32'd64;
    dS[3] = 64'hffff_ffff_ffff_ffff; sS[3] = 64'h1;                   iS[3] = 32'hffff_fff0;
    dS[4] = 64'h0000_0001_0000_0000; sS[4] = 64'h0000_0001_0000_0000; iS[4] = 32'd0;
    dS[5] = 64'h123;                 sS[5] = 64'h7;                   iS[5] = 32'd8;
    dS[6] = 64'hdead_beef_cafe_babe; sS[6] = 64'h2a;                  iS[6] = 32'h7fff_ffff;
    dS[7] = 64'h0;                   sS[7] = 64'hdead;                iS[7] = 32'h8000_0000;

    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", result, 64'd0, illegal, 1'b0, 8'h00);
    checks++;
    if (outValid !== 1'b0) begin
      errors++;
      $display("FAIL R1 outValid=%b expected=0", outValid);
    end
    rstN = 1'b1;

    // R4: 64-bit add with negative immediate sign-extends
    runOne(8'h07, 64'h10, 64'h0, 32'hffff_ffff, "R4");
    check("R4", result, 64'hf, illegal, 1'b0, 8'h07);
    // R5: 32-bit add wraps and zero-extends
    runOne(8'h0c, 64'hffff_ffff_ffff_ffff, 64'h2, 32'h0, "R5");
    check("R5", result, 64'h1, illegal, 1'b0, 8'h0c);
    // R10: big-endian 32
    runOne(8'hdc, 64'h1122_3344_5566_7788, 64'h0, 32'd32, "R10");
    check("R10", result, 64'h8877_6655, illegal, 1'b0, 8'hdc);

    // R1: idle cycle clears outputs
    @(negedge clk);
    check("R1", result, 64'd0, illegal, 1'b0, 8'h00);

    for (int op = 0; op < 256; op++) begin
      for (int k = 0; k < 8; k++) begin
        runOne(8'(op), dS[k], sS[k], iS[k], tagOf(8'(op)));
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule